// File: doc/BRIEF.md
# Misaligned Word Access Bridge

This block sits between a CPU port and a RAM that is four bytes wide and addressed by word. The CPU may ask for a 32-bit or a 16-bit quantity at any byte address. If every requested byte lies inside one aligned word, the bridge makes a single RAM access. If the bytes cross into the next word, it makes two accesses in a row: first the aligned word that holds the first byte, then the word after it. On reads it merges the two partial words into one right-justified result. On writes it splits the data and gives each RAM write its own byte strobes. The bridge never faults on a misaligned address.

The CPU side uses a valid/ready handshake. The CPU raises `req_valid` and holds the request steady. The bridge raises `req_ready` for exactly one cycle, in the cycle the access finishes, and the read data is valid in that cycle. The RAM is synchronous and returns read data one cycle after `mem_en`. Byte order is big-endian: the byte at the lowest address is the most significant byte. A flag output tells whether the access that finished last needed two RAM accesses.

Top module: `misaligned_access_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready`, `mem_en` and `last_split` are all 0.
- R2: An access is non-straddling when it is a 32-bit access at byte offset 0, or a 16-bit access at byte offset 0, 1 or 2. Such an access makes one RAM access, at the word address `req_addr[ADDR_W-1:2]`, in the cycle the request is first seen. `req_ready` is high in the following cycle.
- R3: Any other access makes two RAM accesses in consecutive cycles: first at word w, then at word w+1. `req_ready` is high in the cycle after the second access.
- R4: Read data is big-endian. A 32-bit read returns the byte at `req_addr` in `rsp_rdata[31:24]`, followed by the next three bytes in address order. A 16-bit read returns its two bytes in `rsp_rdata[15:0]` in the same order, with `rsp_rdata[31:16]` = 0. For example, with bytes 0x01..0x08 at addresses 0..7, a 32-bit read at address 1 returns 0x02030405.
- R5: On a write, `mem_be[i]` enables `mem_wdata[8i+7:8i]`, which is the byte at offset 3-i inside the word. Only the lanes of the addressed bytes are enabled. A straddling write enables the upper-address lanes of word w in its first access and the lower-address lanes of word w+1 in its second. Every write access enables at least one lane. In 16-bit mode the write data comes from `req_wdata[15:0]`.
- R6: Every read access to the RAM drives `mem_be` = 0.
- R7: `req_ready` is never high in two consecutive cycles. The next request's first RAM access comes no earlier than the cycle after the completing cycle.
- R8: From the cycle after a completion, `last_split` is 1 if that access used two RAM accesses and 0 if it used one.
- R9: The word address wraps: a straddling access at the top word makes its second access at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until ready |
| req_ready | output | 1 | Access finishes this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_rdata | output | 32 | Read result, valid when req_ready |
| last_split | output | 1 | Last finished access used two RAM accesses |
| mem_en | output | 1 | RAM access strobe |
| mem_addr | output | ADDR_W-2 | RAM word address |
| mem_be | output | 4 | RAM byte write enables |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after mem_en |

## Verification
The bench builds the bridge with ADDR_W = 8, so the RAM has 64 words and a byte reference copy of it stays small. At that width the top word is easy to reach, so an access that wraps from word 63 to word 0 is tested in both directions. Every byte offset is swept in both access widths, and writes are read back through the bridge.

// File: rtl/misaligned_access_bridge.sv
module misaligned_access_bridge #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              last_split,
  output logic              mem_en,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int WA_W = ADDR_W - 2;

  typedef enum logic [1:0] {IDLE, FIRST, SECOND} st_t;
  st_t st;
  logic [31:0] lo_q;

  logic [1:0]      off;
  logic [WA_W-1:0] wa;
  logic            split;
  logic [63:0]     wsh;
  logic [7:0]      msk;
  logic [63:0]     rcat;
  logic [31:0]     rtop;

  assign off   = req_addr[1:0];
  assign wa    = req_addr[ADDR_W-1:2];
  assign split = req_wide ? (off != 2'd0) : (off == 2'd3);

  assign wsh = (req_wide ? {req_wdata, 32'h0} : {req_wdata[15:0], 48'h0}) >> {off, 3'b000};
  assign msk = (req_wide ? 8'hF0 : 8'hC0) >> off;

  assign rcat = (st == SECOND) ? {lo_q, mem_rdata} : {mem_rdata, 32'h0};
  assign rtop = 32'(rcat >> (6'd32 - {1'b0, off, 3'b000}));
  assign rsp_rdata = req_wide ? rtop : {16'h0, rtop[31:16]};

  assign mem_en    = (st == IDLE && req_valid) || (st == FIRST && split);
  assign mem_addr  = (st == FIRST) ? wa + WA_W'(1) : wa;
  assign mem_be    = (mem_en && req_write) ? ((st == FIRST) ? msk[3:0] : msk[7:4]) : 4'h0;
  assign mem_wdata = (st == FIRST) ? wsh[31:0] : wsh[63:32];
  assign req_ready = (st == FIRST && !split) || st == SECOND;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      lo_q       <= 32'h0;
      last_split <= 1'b0;
    end else begin
      case (st)
        IDLE:   if (req_valid) st <= FIRST;
        FIRST:  if (split) begin
                  lo_q <= mem_rdata;
                  st   <= SECOND;
                end else begin
                  st         <= IDLE;
                  last_split <= 1'b0;
                end
        SECOND: begin
                  st         <= IDLE;
                  last_split <= 1'b1;
                end
        default: st <= IDLE;
      endcase
    end
  end

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R3
  second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FIRST && mem_en) |-> mem_addr == WA_W'($past(mem_addr) + 1'b1));

  // R6
  read_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_write) |-> mem_be == 4'h0);

  // R5
  write_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && req_write) |-> mem_be != 4'h0);

  // R2
  done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> $past(mem_en));
endmodule

// File: tb/test_misaligned_access_bridge.sv
`timescale 1ns/100ps
module test_misaligned_access_bridge;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, last_split, mem_en;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-3:0] mem_addr;
  logic [3:0] mem_be;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  misaligned_access_bridge #(.ADDR_W(AW)) i_misaligned_access_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .last_split(last_split),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [31:0] ram [64];
  logic [7:0]  refb [256];

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= ram[mem_addr];
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) ram[mem_addr][8*i +: 8] <= mem_wdata[8*i +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be);
    for (int i = 0; i < 4; i++) lanes[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
  endfunction

  task automatic access(input bit wr, input bit wide, input logic [AW-1:0] addr, input logic [31:0] wd);
    int nb, off;
    bit sp;
    logic [5:0] w;
    logic [3:0] be_e [2];
    logic [31:0] wd_e [2];
    logic [31:0] rd_e;
    nb = wide ? 4 : 2;
    off = int'(addr[1:0]);
    sp = (off + nb) > 4;
    w = addr[AW-1:2];
    be_e[0] = 0; be_e[1] = 0; wd_e[0] = 0; wd_e[1] = 0; rd_e = 0;
    for (int k = 0; k < nb; k++) begin
      int p, wi, ln;
      logic [7:0] b;
      p = off + k; wi = p / 4; ln = 3 - (p % 4);
      b = wide ? wd[31-8*k -: 8] : wd[15-8*k -: 8];
      be_e[wi][ln] = 1'b1;
      wd_e[wi][8*ln +: 8] = b;
      rd_e = (rd_e << 8) | 32'(refb[(int'(addr) + k) % 256]);
    end
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = addr; req_wdata = wd;
    #1;
    check(mem_en == 1'b1, "R2 first access issued", 32'(mem_en), 1);
    check(mem_addr == w, "R2 first word address", 32'(mem_addr), 32'(w));
    if (wr) begin
      check(mem_be == be_e[0], "R5 first strobes", 32'(mem_be), 32'(be_e[0]));
      check((mem_wdata & lanes(be_e[0])) == wd_e[0], "R5 first data", mem_wdata & lanes(be_e[0]), wd_e[0]);
    end else
      check(mem_be == 4'h0, "R6 read strobes", 32'(mem_be), 0);
    @(posedge clk); @(negedge clk); #1;
    if (sp) begin
      check(req_ready == 1'b0, "R3 not ready after first", 32'(req_ready), 0);
      check(mem_en == 1'b1, "R3 second access issued", 32'(mem_en), 1);
      check(mem_addr == w + 6'd1, "R3 R9 second word address", 32'(mem_addr), 32'(w + 6'd1));
      if (wr) begin
        check(mem_be == be_e[1], "R5 second strobes", 32'(mem_be), 32'(be_e[1]));
        check((mem_wdata & lanes(be_e[1])) == wd_e[1], "R5 second data", mem_wdata & lanes(be_e[1]), wd_e[1]);
      end else
        check(mem_be == 4'h0, "R6 read strobes second", 32'(mem_be), 0);
      @(posedge clk); @(negedge clk); #1;
    end
    check(req_ready == 1'b1, sp ? "R3 ready" : "R2 ready", 32'(req_ready), 1);
    check(mem_en == 1'b0, "R7 no access in done cycle", 32'(mem_en), 0);
    if (!wr) check(rsp_rdata == rd_e, "R4 read data", rsp_rdata, rd_e);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(req_ready == 1'b0, "R7 ready one cycle", 32'(req_ready), 0);
    check(last_split == sp, "R8 split flag", 32'(last_split), 32'(sp));
    if (wr)
      for (int k = 0; k < nb; k++)
        refb[(int'(addr) + k) % 256] = wide ? wd[31-8*k -: 8] : wd[15-8*k -: 8];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) refb[a] = 8'(a + 1);
    for (int w = 0; w < 64; w++)
      ram[w] = {refb[4*w], refb[4*w+1], refb[4*w+2], refb[4*w+3]};
    repeat (3) @(negedge clk);
    check(req_ready == 0 && mem_en == 0 && last_split == 0, "R1 reset outputs",
          {29'h0, req_ready, mem_en, last_split}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 0 && mem_en == 0 && last_split == 0, "R1 after reset",
          {29'h0, req_ready, mem_en, last_split}, 0);

    access(0, 1, 8'd0, 0);      // R2 aligned word 0x01020304
    access(0, 1, 8'd1, 0);      // R3 R4 0x02030405
    access(0, 0, 8'd5, 0);      // R2 half, one access
    access(0, 0, 8'd3, 0);      // R3 half straddle
    access(0, 0, 8'd7, 0);
    access(1, 1, 8'd6, 32'hAABBCCDD);  // R5 split write
    access(0, 1, 8'd4, 0);
    access(0, 1, 8'd8, 0);
    access(1, 0, 8'd1, 32'h0000_1122);
    access(1, 0, 8'd3, 32'hFFFF_3344); // upper half ignored in 16-bit mode
    access(0, 1, 8'd0, 0);
    access(0, 1, 8'd254, 0);    // R9 wrap read
    access(1, 1, 8'd253, 32'h5566_7788); // R9 wrap write
    access(0, 1, 8'd252, 0);
    access(0, 1, 8'd0, 0);
    for (int a = 16; a < 40; a++) begin
      access(0, 1, 8'(a), 0);
      access(0, 0, 8'(a), 0);
    end
    for (int a = 40; a < 48; a++) access(1, a[0], 8'(a), 32'h9000_0000 + 32'(a * 257));
    for (int a = 38; a < 52; a++) access(0, 1, 8'(a), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule